// File: doc/BRIEF.md
# Dual-Clock Elastic Word Buffer with Pointer Re-centering

This block sits between a word source on one clock and a word consumer on a second clock. The two clocks run at the same rate, but their phases can differ by a fixed amount and can drift slowly against each other. Words are stored on rising edges of `wr_clk` when `wr_en` is high. They are delivered on `rd_data`, one per rising edge of `rd_clk` when `rd_en` is high. The store holds eight 16-bit words. Each pointer crosses into the other clock domain as a Gray-coded value with a wrap bit, through a two-flop synchronizer.

The read pointer is not emptied back to a start position. Instead it is re-centered mid-stream to four words behind the synchronized write pointer, which leaves room for three words of drift either way. A re-center happens on the level input `recenter_req`, on every rising edge of `lock_in`, and once after reset. Both requests are synchronized into the read domain. A write while full and a read while empty both set the single sticky flag `fifo_err`. A re-center clears this flag, so `fifo_err` can be looped straight back onto `recenter_req`.

The read side runs a small state machine:
- ST_INIT is the single cycle after reset. It always moves to ST_CENTER.
- ST_CENTER places the read pointer and clears the error. It stays there while the synchronized request is high, and otherwise moves to ST_RUN.
- ST_RUN serves reads. It moves to ST_CENTER on a synchronized request or on a synchronized rising edge of `lock_in`.

Top module: `txfifo_recenter`

## Requirements
- R1: While `rst_n` is low and after it is released, `fifo_err` is 0 and `rd_data` is 0 until the first read that takes a word.
- R2: With writes and reads both running every cycle after a re-center, every word comes out once, in write order, with no error.
- R3: After a re-center with writes idle, exactly the last four words written are readable, oldest first.
- R4: From the re-centered point, up to three extra words can be buffered (seven held in total) and then all drained, without raising `fifo_err`.
- R5: A write while eight words are held is dropped and sets `fifo_err`. A read while empty sets `fifo_err` and leaves `rd_data` unchanged.
- R6: `fifo_err` stays high until the next re-center, and a re-center clears it.
- R7: A rising edge of `lock_in` causes a re-center. `lock_in` held high, or falling, causes none.
- R8: With `fifo_err` tied to `recenter_req`, an error clears itself, and the buffer again holds the last four written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| wr_en | input | 1 | Store `wr_data` on this `wr_clk` edge |
| wr_data | input | 16 | Word to store |
| rd_en | input | 1 | Take one word on this `rd_clk` edge |
| recenter_req | input | 1 | Level request to re-center (asynchronous) |
| lock_in | input | 1 | Lock indication; its rising edge triggers a re-center |
| rd_data | output | 16 | Last word taken, registered |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
If a pointer or the centering offset is wrong, the data stream shows it at the first read after a re-center: the words delivered are not the last four written, or one word is duplicated or skipped. A wrong full or empty decision shows up either as a false `fifo_err` or as a missing one. A missing underflow flag is visible on the very next read edge. A missing overflow flag is visible within about four read cycles, once the overflow event has been synchronized. A wrong re-center trigger shows up as `fifo_err` failing to clear, or clearing when `lock_in` is only held high or falling.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_CENTER = 2'd1,
        ST_RUN    = 2'd2
    } rd_state_t;
endpackage

// File: rtl/txf_sync.sv
module txf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/txf_wr_side.sv
module txf_wr_side #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                      wr_clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(DEPTH):0]    rd_gray_s,
    output logic [$clog2(DEPTH):0]    wr_gray,
    output logic                      ovf_tgl,
    output logic                      full,
    output logic [DEPTH*DW-1:0]       mem_flat
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] wr_bin_nxt;
    logic [PTR_W-1:0] rd_bin_s;

    always_comb begin
        rd_bin_s[PTR_W-1] = rd_gray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
        end
    end

    assign wr_bin_nxt = wr_bin + PTR_W'(1);
    assign full       = ((wr_bin - rd_bin_s) == PTR_W'(DEPTH));

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            ovf_tgl <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_tgl <= ~ovf_tgl;
            end else begin
                wr_bin  <= wr_bin_nxt;
                wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) begin
            mem[wr_bin[AW-1:0]] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign mem_flat[g*DW +: DW] = mem[g];
    end
endmodule

// File: rtl/txf_rd_side.sv
module txf_rd_side
    import txf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                      rd_clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [DEPTH*DW-1:0]       mem_flat,
    input  logic [$clog2(DEPTH):0]    wr_gray_s,
    input  logic                      req_s,
    input  logic                      lock_s,
    input  logic                      ovf_tgl_s,
    output logic [DW-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]    rd_gray,
    output logic                      fifo_err,
    output logic                      centering,
    output logic                      rd_live,
    output logic                      empty
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;

    rd_state_t        state_q, state_d;
    logic [PTR_W-1:0] rd_bin, rd_bin_nxt, wr_bin_s, ctr_bin;
    logic             lock_d, ovf_d, lock_rise, ovf_evt;
    logic             rd_go, udf;

    always_comb begin
        wr_bin_s[PTR_W-1] = wr_gray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
        end
    end

    assign lock_rise  = lock_s & ~lock_d;
    assign ovf_evt    = ovf_tgl_s ^ ovf_d;
    assign empty      = (wr_bin_s == rd_bin);
    assign rd_bin_nxt = rd_bin + PTR_W'(1);
    assign ctr_bin    = wr_bin_s - PTR_W'(DEPTH / 2);

    // state register
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   state_d = ST_CENTER;
            ST_CENTER: state_d = req_s ? ST_CENTER : ST_RUN;
            ST_RUN:    state_d = (req_s || lock_rise) ? ST_CENTER : ST_RUN;
            default:   state_d = ST_INIT;
        endcase
    end

    // state outputs
    always_comb begin
        centering = 1'b0;
        rd_live   = 1'b0;
        unique case (state_q)
            ST_INIT:   ;
            ST_CENTER: centering = 1'b1;
            ST_RUN:    rd_live   = 1'b1;
            default:   ;
        endcase
        rd_go = rd_live && rd_en && !empty;
        udf   = rd_live && rd_en && empty;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin   <= '0;
            rd_gray  <= '0;
            rd_data  <= '0;
            fifo_err <= 1'b0;
            lock_d   <= 1'b0;
            ovf_d    <= 1'b0;
        end else begin
            lock_d <= lock_s;
            ovf_d  <= ovf_tgl_s;
            if (centering) begin
                rd_bin   <= ctr_bin;
                rd_gray  <= ctr_bin ^ (ctr_bin >> 1);
                fifo_err <= 1'b0;
            end else begin
                if (rd_go) begin
                    rd_data <= mem_flat[rd_bin[AW-1:0]*DW +: DW];
                    rd_bin  <= rd_bin_nxt;
                    rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
                end
                if (udf || ovf_evt) fifo_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txfifo_recenter.sv
module txfifo_recenter #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          recenter_req,
    input  logic          lock_in,
    output logic [DW-1:0] rd_data,
    output logic          fifo_err
);
    localparam int PTR_W = $clog2(DEPTH) + 1;

    logic [PTR_W-1:0]    wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [DEPTH*DW-1:0] mem_flat;
    logic                ovf_tgl, full, empty, centering, rd_live;
    logic [2:0]          ctl_s;

    txf_wr_side #(.DW(DW), .DEPTH(DEPTH)) u_wr (
        .wr_clk   (wr_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_gray_s(rd_gray_s),
        .wr_gray  (wr_gray),
        .ovf_tgl  (ovf_tgl),
        .full     (full),
        .mem_flat (mem_flat)
    );

    txf_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    txf_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    txf_sync #(.W(3)) u_sync_ctl (
        .clk(rd_clk), .rst_n(rst_n),
        .d({recenter_req, lock_in, ovf_tgl}), .q(ctl_s)
    );

    txf_rd_side #(.DW(DW), .DEPTH(DEPTH)) u_rd (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .mem_flat (mem_flat),
        .wr_gray_s(wr_gray_s),
        .req_s    (ctl_s[2]),
        .lock_s   (ctl_s[1]),
        .ovf_tgl_s(ctl_s[0]),
        .rd_data  (rd_data),
        .rd_gray  (rd_gray),
        .fifo_err (fifo_err),
        .centering(centering),
        .rd_live  (rd_live),
        .empty    (empty)
    );
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
    parameter int DW    = 16,
    parameter int PTR_W = 4
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             full,
    input logic [PTR_W-1:0] wr_gray,
    input logic             rd_en,
    input logic             empty,
    input logic             centering,
    input logic             rd_live,
    input logic [DW-1:0]    rd_data,
    input logic             fifo_err
);
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(wr_gray ^ $past(wr_gray))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_gray)); // R5

    AST_UNDERFLOW_FLAG: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_live && rd_en && empty) |=> (fifo_err && $stable(rd_data))); // R5

    AST_CENTER_CLEARS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        centering |=> !fifo_err); // R6

    AST_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fifo_err && !centering) |=> fifo_err); // R6
endmodule

bind txfifo_recenter txf_checker #(.DW(DW), .PTR_W(PTR_W)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .full     (full),
    .wr_gray  (wr_gray),
    .rd_en    (rd_en),
    .empty    (empty),
    .centering(centering),
    .rd_live  (rd_live),
    .rd_data  (rd_data),
    .fifo_err (fifo_err)
);

// File: tb/txfifo_recenter_test.sv
module txfifo_recenter_test;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        wr_en  = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en  = 1'b0;
    logic        req_drv = 1'b0;
    logic        fb_on  = 1'b0;
    logic        lock_in = 1'b0;
    logic        recenter_req;
    logic [15:0] rd_data;
    logic        fifo_err;

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [15:0] seq    = 16'h1000;

    assign recenter_req = fb_on ? fifo_err : req_drv;

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    txfifo_recenter uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .recenter_req(recenter_req), .lock_in(lock_in),
        .rd_data(rd_data), .fifo_err(fifo_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = seq;
            seq++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_one(output logic [15:0] v);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic recenter();
        @(negedge rd_clk);
        req_drv = 1'b1;
        rd_wait(3);
        req_drv = 1'b0;
        rd_wait(8);
    endtask

    task automatic read_expect(input int n, input logic [15:0] first, input string tag);
        logic [15:0] v;
        for (int i = 0; i < n; i++) begin
            rd_one(v);
            chk(v == first + 16'(i), tag, v, first + 16'(i));
        end
        chk(fifo_err == 1'b0, tag, fifo_err, 0);
    endtask

    task automatic t_reset();
        chk(fifo_err == 1'b0, "R1 err", fifo_err, 0);
        chk(rd_data == 16'h0, "R1 data", rd_data, 0);
    endtask

    task automatic t_stream();
        logic [15:0] base;
        base = seq;
        wr_burst(4);
        rd_wait(8);
        recenter();
        fork
            wr_burst(60);
            begin
                @(negedge rd_clk);
                @(negedge rd_clk);
                rd_en = 1'b1;
                for (int i = 0; i < 60; i++) begin
                    @(negedge rd_clk);
                    chk(rd_data == base + 16'(i), "R2 order", rd_data, base + 16'(i));
                    rd_en = (i < 59);
                end
            end
        join
        rd_wait(8);
        chk(fifo_err == 1'b0, "R2 no error", fifo_err, 0);
    endtask

    logic [15:0] w0, x0, y0;

    task automatic t_center();
        logic [15:0] v;
        w0 = seq;
        wr_burst(4);
        rd_wait(8);
        recenter();
        read_expect(4, w0, "R3 last four");
        rd_one(v);
        chk(fifo_err == 1'b1, "R5 underflow err", fifo_err, 1);
        chk(v == w0 + 16'd3, "R5 underflow data held", v, w0 + 16'd3);
    endtask

    task automatic t_sticky();
        rd_wait(12);
        chk(fifo_err == 1'b1, "R6 sticky", fifo_err, 1);
        recenter();
        chk(fifo_err == 1'b0, "R6 cleared", fifo_err, 0);
    endtask

    task automatic t_wander();
        x0 = seq;
        wr_burst(3);
        rd_wait(8);
        chk(fifo_err == 1'b0, "R4 seven held", fifo_err, 0);
        read_expect(4, w0, "R4 drain old");
        read_expect(3, x0, "R4 drain new");
    endtask

    task automatic t_overflow();
        recenter();
        y0 = seq;
        wr_burst(4);
        rd_wait(8);
        chk(fifo_err == 1'b0, "R5 eight held", fifo_err, 0);
        wr_burst(1);
        rd_wait(8);
        chk(fifo_err == 1'b1, "R5 overflow err", fifo_err, 1);
        recenter();
        read_expect(4, y0, "R5 dropped write");
    endtask

    task automatic t_lock();
        logic [15:0] v;
        rd_one(v);
        chk(fifo_err == 1'b1, "R7 setup err", fifo_err, 1);
        @(negedge rd_clk);
        lock_in = 1'b1;
        rd_wait(8);
        chk(fifo_err == 1'b0, "R7 rise recenters", fifo_err, 0);
        read_expect(4, y0, "R7 data after lock");
        rd_one(v);
        rd_wait(12);
        chk(fifo_err == 1'b1, "R7 high holds", fifo_err, 1);
        lock_in = 1'b0;
        rd_wait(12);
        chk(fifo_err == 1'b1, "R7 fall no effect", fifo_err, 1);
        recenter();
    endtask

    task automatic t_feedback();
        logic [15:0] v;
        fb_on = 1'b1;
        read_expect(4, y0, "R8 drain");
        rd_one(v);
        rd_wait(10);
        chk(fifo_err == 1'b0, "R8 self clear", fifo_err, 0);
        read_expect(4, y0, "R8 refilled view");
        fb_on = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #5;
        t_reset();
        #98;
        rst_n = 1'b1;
        rd_wait(6);
        t_reset();
        t_stream();
        t_center();
        t_sticky();
        t_wander();
        t_overflow();
        t_lock();
        t_feedback();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule